// File: doc/BRIEF.md
# Table Pointer Read/Write Unit

This unit carries out the byte transfers between a processor's data side and its program memory. It keeps a 21-bit program-memory pointer and an 8-bit holding latch. When the core presents a table-transfer instruction word together with a one-cycle strobe, the unit either fetches one program-memory byte into the latch or offers the latch contents to memory as a write. Around the access it adjusts the pointer in one of four ways, chosen by the two low bits of the instruction.

Software loads the pointer and the latch through two plain register-write ports. The memory side is a single byte-wide port with a request, a write enable, an address, write data and read data. Read data is returned on the cycle after the request. Each transfer keeps the unit busy for two cycles. Strobes that arrive during that time are dropped.

Top module: `tbl_access_unit`

## Requirements
- R1: After reset the pointer and the latch read zero, and `busy_o`, `mem_req_o` and `mem_we_o` are low.
- R2: With `busy_o` low, a strobe starts a transfer only when bits 15..3 of `instr_i` equal 0000000000001. Bit 2 selects the direction: 0 reads and 1 writes. Every other instruction word starts nothing.
- R3: Instruction bits 1..0 choose the pointer update. 00 leaves the pointer unchanged. 01 adds one after the access. 10 subtracts one after the access. 11 adds one before the access, so the incremented address is the one accessed.
- R4: Pointer increment and decrement wrap modulo 2^21: 1FFFFFh plus one gives 0, and 0 minus one gives 1FFFFFh.
- R5: `busy_o` is high for exactly the two cycles that follow the accepting clock edge. `mem_req_o` is high in the first of those two cycles only.
- R6: On a read, `mem_we_o` stays low during the request. The latch takes `mem_rdata_i` at the end of the second busy cycle, one cycle after the request.
- R7: On a write, `mem_we_o` is high together with `mem_req_o` for one cycle, and `mem_wdata_o` equals the latch.
- R8: A strobe that arrives while `busy_o` is high has no effect on the pointer, on the latch or on the memory port.
- R9: `ptr_wr_i` and `latch_wr_i` load their values at the next edge when the unit is idle. They are ignored while the unit is busy, and also on the edge at which a strobe is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 16 | Instruction word, sampled together with the strobe |
| strobe_i | input | 1 | Requests execution of `instr_i` |
| ptr_wr_i | input | 1 | Pointer load enable |
| ptr_wdata_i | input | 21 | Pointer load value |
| latch_wr_i | input | 1 | Latch load enable |
| latch_wdata_i | input | 8 | Latch load value |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write enable, valid together with the request |
| mem_addr_o | output | 21 | Memory byte address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, valid on the cycle after a read request |
| busy_o | output | 1 | A transfer is in progress |
| ptr_o | output | 21 | Current pointer |
| latch_o | output | 8 | Current latch |

## Verification
The assertions assume that the memory returns read data exactly one cycle after a read request. They also assume that the instruction word is stable in the cycle it is strobed. The bench memory model is a register that captures a byte computed from the address on each read request, so the response timing always matches that assumption. The sweep drives every combination of direction, update mode and boundary pointer value, including extra strobes and register writes issued while the unit is busy. It then offers every low-byte instruction word, plus words with upper bits set, to show that only the eight table encodings start a transfer.

// File: rtl/tbl_pkg.sv
package tbl_pkg;
  typedef enum logic [1:0] {
    ADJ_NONE     = 2'b00,
    ADJ_POST_INC = 2'b01,
    ADJ_POST_DEC = 2'b10,
    ADJ_PRE_INC  = 2'b11
  } adj_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_FINISH = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic      hit;
    logic      is_write;
    adj_mode_e mode;
  } tbl_op_t;
endpackage

// File: rtl/tbl_op_decode.sv
module tbl_op_decode
  import tbl_pkg::*;
#(
  parameter int INSTR_W = 16
) (
  input  logic [INSTR_W-1:0] instr_i,
  output tbl_op_t            op_o
);
  localparam int HI_W = INSTR_W - 4;

  always_comb begin
    op_o.hit      = (instr_i[INSTR_W-1:4] == {HI_W{1'b0}}) && instr_i[3];
    op_o.is_write = instr_i[2];
    op_o.mode     = adj_mode_e'(instr_i[1:0]);
  end
endmodule

// File: rtl/tbl_ptr_reg.sv
module tbl_ptr_reg #(
  parameter int PTR_W = 21
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [PTR_W-1:0] load_val_i,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [PTR_W-1:0] ptr_o
);
  localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

  logic [PTR_W-1:0] ptr_q, ptr_d;

  // natural width wrap gives modulo 2^PTR_W
  always_comb begin
    ptr_d = ptr_q;
    if (inc_i)       ptr_d = ptr_q + ONE;
    else if (dec_i)  ptr_d = ptr_q - ONE;
    else if (load_i) ptr_d = load_val_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else         ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/tbl_latch_reg.sv
module tbl_latch_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sw_load_i,
  input  logic [DATA_W-1:0] sw_val_i,
  input  logic              mem_load_i,
  input  logic [DATA_W-1:0] mem_val_i,
  output logic [DATA_W-1:0] latch_o
);
  logic [DATA_W-1:0] latch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         latch_q <= '0;
    else if (mem_load_i) latch_q <= mem_val_i;
    else if (sw_load_i)  latch_q <= sw_val_i;
  end

  assign latch_o = latch_q;
endmodule

// File: rtl/tbl_seq.sv
module tbl_seq
  import tbl_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    strobe_i,
  input  tbl_op_t op_i,
  output logic    accept_o,
  output logic    ptr_inc_o,
  output logic    ptr_dec_o,
  output logic    latch_capture_o,
  output logic    reg_wr_ok_o,
  output logic    mem_req_o,
  output logic    mem_we_o,
  output logic    busy_o
);
  seq_state_e state_q, state_d;
  logic       wr_q;
  adj_mode_e  mode_q;

  assign accept_o = (state_q == ST_IDLE) && strobe_i && op_i.hit;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (accept_o) state_d = ST_ACCESS;
      ST_ACCESS: state_d = ST_FINISH;
      ST_FINISH: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      wr_q    <= 1'b0;
      mode_q  <= ADJ_NONE;
    end else begin
      state_q <= state_d;
      if (accept_o) begin
        wr_q   <= op_i.is_write;
        mode_q <= op_i.mode;
      end
    end
  end

  // pre-increment lands before the access cycle, post updates after it
  assign ptr_inc_o = (accept_o && op_i.mode == ADJ_PRE_INC) ||
                     (state_q == ST_ACCESS && mode_q == ADJ_POST_INC);
  assign ptr_dec_o = (state_q == ST_ACCESS) && (mode_q == ADJ_POST_DEC);

  assign latch_capture_o = (state_q == ST_FINISH) && !wr_q;
  assign reg_wr_ok_o     = (state_q == ST_IDLE) && !accept_o;
  assign mem_req_o       = (state_q == ST_ACCESS);
  assign mem_we_o        = (state_q == ST_ACCESS) && wr_q;
  assign busy_o          = (state_q != ST_IDLE);
endmodule

// File: rtl/tbl_access_unit.sv
module tbl_access_unit
  import tbl_pkg::*;
#(
  parameter int INSTR_W = 16,
  parameter int PTR_W   = 21,
  parameter int DATA_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic               strobe_i,
  input  logic               ptr_wr_i,
  input  logic [PTR_W-1:0]   ptr_wdata_i,
  input  logic               latch_wr_i,
  input  logic [DATA_W-1:0]  latch_wdata_i,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [PTR_W-1:0]   mem_addr_o,
  output logic [DATA_W-1:0]  mem_wdata_o,
  input  logic [DATA_W-1:0]  mem_rdata_i,
  output logic               busy_o,
  output logic [PTR_W-1:0]   ptr_o,
  output logic [DATA_W-1:0]  latch_o
);
  tbl_op_t op;
  logic    accept, ptr_inc, ptr_dec, latch_cap, reg_wr_ok;

  tbl_op_decode #(.INSTR_W(INSTR_W)) u_dec (
    .instr_i (instr_i),
    .op_o    (op)
  );

  tbl_seq u_seq (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .strobe_i        (strobe_i),
    .op_i            (op),
    .accept_o        (accept),
    .ptr_inc_o       (ptr_inc),
    .ptr_dec_o       (ptr_dec),
    .latch_capture_o (latch_cap),
    .reg_wr_ok_o     (reg_wr_ok),
    .mem_req_o       (mem_req_o),
    .mem_we_o        (mem_we_o),
    .busy_o          (busy_o)
  );

  tbl_ptr_reg #(.PTR_W(PTR_W)) u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ptr_wr_i && reg_wr_ok),
    .load_val_i (ptr_wdata_i),
    .inc_i      (ptr_inc),
    .dec_i      (ptr_dec),
    .ptr_o      (ptr_o)
  );

  tbl_latch_reg #(.DATA_W(DATA_W)) u_latch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sw_load_i  (latch_wr_i && reg_wr_ok),
    .sw_val_i   (latch_wdata_i),
    .mem_load_i (latch_cap),
    .mem_val_i  (mem_rdata_i),
    .latch_o    (latch_o)
  );

  assign mem_addr_o  = ptr_o;
  assign mem_wdata_o = latch_o;

  // accept is consumed inside the sequencer
  logic unused_accept;
  assign unused_accept = accept;
endmodule

// File: rtl/tbl_access_unit_chk.sv
module tbl_access_unit_chk #(
  parameter int INSTR_W = 16,
  parameter int PTR_W   = 21,
  parameter int DATA_W  = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [INSTR_W-1:0] instr_i,
  input logic               strobe_i,
  input logic               mem_req_o,
  input logic               mem_we_o,
  input logic [PTR_W-1:0]   mem_addr_o,
  input logic [DATA_W-1:0]  mem_wdata_o,
  input logic               busy_o,
  input logic [PTR_W-1:0]   ptr_o,
  input logic [DATA_W-1:0]  latch_o
);
  logic is_tbl, is_pre;
  assign is_tbl = (instr_i[INSTR_W-1:4] == '0) && instr_i[3];
  assign is_pre = is_tbl && (instr_i[1:0] == 2'b11);

  assert_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && strobe_i && is_tbl) |=> (mem_req_o && busy_o));

  assert_no_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !(strobe_i && is_tbl)) |=> !busy_o);

  assert_pre_addr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && strobe_i && is_pre) |=> (mem_addr_o == $past(ptr_o) + PTR_W'(1)));

  assert_two_cycles_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> (busy_o && !mem_req_o));

  assert_finish_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !mem_req_o) |=> !busy_o);

  assert_req_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);

  assert_latch_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> $stable(latch_o));

  assert_we_req_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_req_o && mem_wdata_o == latch_o));

  assert_busy_ptr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !mem_req_o) |=> $stable(ptr_o));
endmodule

bind tbl_access_unit tbl_access_unit_chk #(
  .INSTR_W (INSTR_W),
  .PTR_W   (PTR_W),
  .DATA_W  (DATA_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .instr_i     (instr_i),
  .strobe_i    (strobe_i),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .busy_o      (busy_o),
  .ptr_o       (ptr_o),
  .latch_o     (latch_o)
);

// File: tb/tbl_access_unit_tb.sv
`timescale 1ns/1ps
module tbl_access_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] instr = '0;
  logic        strobe = 1'b0;
  logic        ptr_wr = 1'b0;
  logic [20:0] ptr_wdata = '0;
  logic        latch_wr = 1'b0;
  logic [7:0]  latch_wdata = '0;
  logic        mem_req, mem_we, busy;
  logic [20:0] mem_addr, ptr;
  logic [7:0]  mem_wdata, latch;
  logic [7:0]  mem_rdata = '0;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  tbl_access_unit u_dut (
    .clk_i (clk), .rst_ni (rst_n), .instr_i (instr), .strobe_i (strobe),
    .ptr_wr_i (ptr_wr), .ptr_wdata_i (ptr_wdata),
    .latch_wr_i (latch_wr), .latch_wdata_i (latch_wdata),
    .mem_req_o (mem_req), .mem_we_o (mem_we), .mem_addr_o (mem_addr),
    .mem_wdata_o (mem_wdata), .mem_rdata_i (mem_rdata),
    .busy_o (busy), .ptr_o (ptr), .latch_o (latch)
  );

  function automatic logic [7:0] mem_byte(input logic [20:0] a);
    return a[7:0] ^ a[15:8] ^ {3'b000, a[20:16]} ^ 8'h5A;
  endfunction

  // one-cycle response memory model
  always @(posedge clk) if (mem_req && !mem_we) mem_rdata <= mem_byte(mem_addr);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic do_op(input bit wr, input bit [1:0] mode,
                       input logic [20:0] p0, input logic [7:0] l0);
    logic [20:0] acc, fin;
    acc = (mode == 2'b11) ? p0 + 21'd1 : p0;
    case (mode)
      2'b00: fin = p0;
      2'b01: fin = p0 + 21'd1;
      2'b10: fin = p0 - 21'd1;
      default: fin = p0 + 21'd1;
    endcase
    @(negedge clk);
    ptr_wr = 1'b1; ptr_wdata = p0; latch_wr = 1'b1; latch_wdata = l0;
    @(negedge clk);
    ptr_wr = 1'b0; latch_wr = 1'b0;
    chk("R9 ptr load", ptr, p0);
    chk("R9 latch load", latch, l0);
    instr = {12'h000, 1'b1, wr, mode}; strobe = 1'b1;
    @(negedge clk);
    // first busy cycle; stray strobe and register writes (R8, R9)
    chk("R5 busy c1", busy, 1);
    chk("R5 req c1", mem_req, 1);
    chk(wr ? "R7 we" : "R6 we low", mem_we, wr);
    chk("R3 access addr", mem_addr, acc);
    if (wr) chk("R7 wdata", mem_wdata, l0);
    instr = {12'h000, 1'b1, ~wr, ~mode}; strobe = 1'b1;
    ptr_wr = 1'b1; ptr_wdata = ~p0; latch_wr = 1'b1; latch_wdata = ~l0;
    @(negedge clk);
    chk("R5 busy c2", busy, 1);
    chk("R5 req c2", mem_req, 0);
    @(negedge clk);
    strobe = 1'b0; ptr_wr = 1'b0; latch_wr = 1'b0;
    chk("R5 idle", busy, 0);
    chk("R8 no req", mem_req, 0);
    chk("R3 R4 final ptr", ptr, fin);
    chk(wr ? "R8 R9 latch kept" : "R6 latch read", latch, wr ? l0 : mem_byte(acc));
    @(negedge clk);
    chk("R8 stray ignored", busy, 0);
  endtask

  task automatic run_all();
    logic [20:0] pts [5];
    pts[0] = 21'h000000; pts[1] = 21'h000001; pts[2] = 21'h1FFFFF;
    pts[3] = 21'h0ABCDE; pts[4] = 21'h100000;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 ptr", ptr, 0);
    chk("R1 latch", latch, 0);
    chk("R1 busy", busy, 0);
    chk("R1 req", mem_req, 0);
    chk("R1 we", mem_we, 0);
    rst_n = 1'b1;
    for (int w = 0; w < 2; w++)
      for (int m = 0; m < 4; m++)
        for (int k = 0; k < 5; k++)
          do_op(w[0], m[1:0], pts[k], 8'h3C ^ 8'(k * 17 + m));
    // non-table words start nothing (R2)
    for (int i = 0; i < 256 + 8; i++) begin
      logic [15:0] iw;
      if (i < 256) iw = 16'(i);
      else iw = {4'(i - 255), 12'h008} | 16'h0008;
      if (iw[15:4] == 12'h000 && iw[3]) continue;
      @(negedge clk);
      instr = iw; strobe = 1'b1;
      @(negedge clk);
      strobe = 1'b0;
      chk("R2 non-table busy", busy, 0);
    end
    // strobe and pointer load on the same edge: load is dropped (R9)
    do_op(1'b0, 2'b00, 21'h012345, 8'h11);
    @(negedge clk);
    instr = 16'h0009; strobe = 1'b1; ptr_wr = 1'b1; ptr_wdata = 21'h1F0000;
    @(negedge clk);
    strobe = 1'b0; ptr_wr = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 same-edge load dropped", ptr, 21'h012346);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule